// File: doc/BRIEF.md
# CMOS Gate Internal-Node State Tracker

This block is a clocked, logic-level model of a static CMOS NOR or NAND gate with a parameterised number of inputs. It does not stop at the Boolean output. It keeps one charged or discharged bit for every node between the series transistors, plus one bit for the output node. Each clock it takes the input vector and a gate-type select, and it works out where the conducting paths reach. Nodes that touch a rail take that rail's value. Nodes that touch no rail keep what they held.

When the output node changes, the block raises a one-cycle rise or fall pulse. On a rise it also reports whether the stack node next to the output was already charged. A delay model downstream can use that bit to pick between two rise cases that a plain truth table treats as the same. A programmable energy weight is added into a saturating total on every cycle where the output changes, and nothing is added on the other cycles.

Top module: `cmos_node_tracker`

## Requirements
- R1: While reset is held, and in the first cycle after it, the state equals the state that all-zero inputs give. For NOR that is every bit set. For NAND it is the output bit set and every stack bit clear. Pulses read 0 and the energy total reads 0.
- R2: State bit N-1 is the output node. Bits 0 to N-2 are the stack nodes, with bit 0 nearest the rail that feeds the series chain. With `gate_nand`=0, a series transistor conducts on input 0 and charges nodes to 1, and a parallel transistor conducts on input 1 and pulls the output to 0. With `gate_nand`=1, every one of these values is inverted.
- R3: Rail-side walk: starting at input 0 and moving up, each input whose series transistor conducts sets its node n to the series-path value. The walk stops at the first input that does not conduct.
- R4: Output-side walk: if any parallel transistor conducts, the output takes the opposite value. Then, moving down from input N-1, each conducting series input n copies that value onto node n-1, stopping at the first non-conducting one. Nodes that neither walk reaches keep their value, even if they are newly joined to a charged neighbour.
- R5: `out_rise` or `out_fall` is high for exactly the cycle in which `node_state[N-1]` shows the new output value. The two are never high together.
- R6: For a 2-input NOR run from reset, the state with the output charged and the stack node discharged (`2'b10`) never appears.
- R7: `rise_from_charged` is high only together with `out_rise`. It equals the previous value of state bit N-2. For N=1 it is always 0.
- R8: With N=1, the model reduces to two states, and the state bit is the inverse of the input for both gate types.
- R9: In each cycle where the output changes, `energy_total` grows by `energy_wt`. In every other cycle it holds its value.
- R10: `energy_total` saturates at its all-ones value and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_nand | input | 1 | Gate type: 0 selects NOR, 1 selects NAND |
| in_vec | input | NUM_IN | Gate inputs; bit 0 drives the series transistor nearest the rail |
| energy_wt | input | WT_W | Energy added per output transition |
| node_state | output | NUM_IN | Registered node state; bit NUM_IN-1 is the output node |
| out_rise | output | 1 | One-cycle pulse on an output rise |
| out_fall | output | 1 | One-cycle pulse on an output fall |
| rise_from_charged | output | 1 | On a rise, 1 if the stack node next to the output was charged |
| energy_total | output | ACC_W | Saturating accumulated energy |

## Verification
The assertions check on every cycle that the pulses are exclusive, that they agree with the registered output bit, and that the source bit only appears with a rise. They also check that the energy total never decreases and holds on cycles without a transition. Only the bench scenarios can show that the two directional walks leave floating nodes untouched, that charge is kept rather than shared, and that the 2-input NOR never reaches its forbidden state. The same holds for the inverter reduction and for the exact saturation point of the total. Those scenarios compare three widths and both gate types against an independent reference walk, and they add directed charge-retention sequences.

// File: rtl/cmos_node_pkg.sv
// Package: shared gate-type encoding and polarity helpers for the
// internal-node tracker. Assumes only NOR and NAND static CMOS gates.
package cmos_node_pkg;

    typedef enum logic {
        GK_NOR  = 1'b0,
        GK_NAND = 1'b1
    } gate_kind_e;

    // Input level that turns a series-stack transistor on.
    function automatic logic series_on_level(input gate_kind_e k);
        return (k == GK_NAND);
    endfunction

    // Value a series-conducting path drives onto its nodes.
    function automatic logic series_node_value(input gate_kind_e k);
        return (k == GK_NOR);
    endfunction

    // Value the parallel network drives onto the output node.
    function automatic logic parallel_out_value(input gate_kind_e k);
        return (k == GK_NAND);
    endfunction

endpackage

// File: rtl/cmos_stack_next.sv
// Module: combinational next-state rule for the node vector.
// Phase one walks up from the rail end while series devices conduct.
// Phase two, when any parallel device conducts, sets the output node and
// walks down from it. Nodes reached by neither walk keep their value.
// Assumes NUM_IN >= 1; bit NUM_IN-1 is the output node.
module cmos_stack_next
    import cmos_node_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  gate_kind_e        kind,
    input  logic [NUM_IN-1:0] in_vec,
    input  logic [NUM_IN-1:0] cur_state,
    output logic [NUM_IN-1:0] nxt_state
);
    localparam int OUT_IDX = NUM_IN - 1;

    logic son;
    logic sval;
    logic pval;
    logic par_any;

    // Purpose: derive polarity controls from the gate type.
    always_comb begin
        son     = series_on_level(kind);
        sval    = series_node_value(kind);
        pval    = parallel_out_value(kind);
        par_any = (kind == GK_NAND) ? ~(&in_vec) : (|in_vec);
    end

    // Purpose: apply both conduction walks to the present state.
    always_comb begin
        logic run;
        nxt_state = cur_state;
        run = 1'b1;
        for (int i = 0; i < NUM_IN; i++) begin
            if (run && (in_vec[i] == son)) begin
                nxt_state[i] = sval;
            end else begin
                run = 1'b0;
            end
        end
        if (par_any) begin
            nxt_state[OUT_IDX] = pval;
            run = 1'b1;
            for (int i = OUT_IDX; i >= 1; i--) begin
                if (run && (in_vec[i] == son)) begin
                    nxt_state[i-1] = pval;
                end else begin
                    run = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/cmos_out_edge.sv
// Module: registers rise and fall pulses of the output node and the
// charged-source flag for rises. It takes the present and next state in
// the same cycle, so the pulses line up with the registered state.
module cmos_out_edge #(
    parameter int NUM_IN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] cur_state,
    input  logic [NUM_IN-1:0] nxt_state,
    output logic              rise_q,
    output logic              fall_q,
    output logic              src_chg_q
);
    localparam int OUT_IDX = NUM_IN - 1;

    logic near_node;

    generate
        if (NUM_IN == 1) begin : g_inv
            assign near_node = 1'b0;
        end else begin : g_stack
            assign near_node = cur_state[NUM_IN-2];
        end
    endgenerate

    // Purpose: register output transition flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q    <= 1'b0;
            fall_q    <= 1'b0;
            src_chg_q <= 1'b0;
        end else begin
            rise_q    <= ~cur_state[OUT_IDX] & nxt_state[OUT_IDX];
            fall_q    <= cur_state[OUT_IDX] & ~nxt_state[OUT_IDX];
            src_chg_q <= ~cur_state[OUT_IDX] & nxt_state[OUT_IDX] & near_node;
        end
    end

    // R7: the source flag only accompanies a rise.
    a_r7_src_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
        src_chg_q |-> rise_q);

    // R5: rise and fall never coincide.
    a_r5_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_q && fall_q));

endmodule

// File: rtl/energy_sat_acc.sv
// Module: saturating energy accumulator. Adds the weight on every cycle
// where add_en is high. Assumes ACC_W > WT_W.
module energy_sat_acc #(
    parameter int WT_W  = 16,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [WT_W-1:0]  weight,
    output logic [ACC_W-1:0] total_q
);
    localparam int PAD_W = ACC_W + 1 - WT_W;

    logic [ACC_W:0] sum;

    // Purpose: form the widened sum so a carry marks overflow.
    always_comb begin
        sum = {1'b0, total_q} + {{PAD_W{1'b0}}, weight};
    end

    // Purpose: update the total, clamping at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (add_en) begin
            total_q <= sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
        end
    end

    // R10: the total never decreases, so it cannot wrap.
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        total_q >= $past(total_q));

endmodule

// File: rtl/cmos_node_tracker.sv
// Module: top of the internal-node tracker. Holds the node-state register,
// derives the next state from the conduction rules, and reports transitions
// and accumulated switching energy. Assumes NUM_IN in 1..8 and that
// gate_nand is steady during reset.
module cmos_node_tracker
    import cmos_node_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int WT_W   = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_nand,
    input  logic [NUM_IN-1:0] in_vec,
    input  logic [WT_W-1:0]   energy_wt,
    output logic [NUM_IN-1:0] node_state,
    output logic              out_rise,
    output logic              out_fall,
    output logic              rise_from_charged,
    output logic [ACC_W-1:0]  energy_total
);
    localparam int OUT_IDX = NUM_IN - 1;
    localparam logic [NUM_IN-1:0] NAND_RST = NUM_IN'(1) << OUT_IDX;
    localparam logic [NUM_IN-1:0] NOR_RST  = {NUM_IN{1'b1}};

    gate_kind_e        kind;
    logic [NUM_IN-1:0] state_q;
    logic [NUM_IN-1:0] state_d;
    logic              out_toggle;

    assign kind = gate_kind_e'(gate_nand);

    cmos_stack_next #(.NUM_IN(NUM_IN)) u_next (
        .kind      (kind),
        .in_vec    (in_vec),
        .cur_state (state_q),
        .nxt_state (state_d)
    );

    // Purpose: hold the node state; reset to the all-zero-input settle point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= gate_nand ? NAND_RST : NOR_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_toggle = state_d[OUT_IDX] ^ state_q[OUT_IDX];

    cmos_out_edge #(.NUM_IN(NUM_IN)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_state (state_q),
        .nxt_state (state_d),
        .rise_q    (out_rise),
        .fall_q    (out_fall),
        .src_chg_q (rise_from_charged)
    );

    energy_sat_acc #(.WT_W(WT_W), .ACC_W(ACC_W)) u_energy (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (out_toggle),
        .weight  (energy_wt),
        .total_q (energy_total)
    );

    assign node_state = state_q;

    // R5: a rise pulse appears with the output bit newly set.
    a_r5_rise_tracks_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_rise |-> (state_q[OUT_IDX] && !$past(state_q[OUT_IDX])));

    // R5: a fall pulse appears with the output bit newly cleared.
    a_r5_fall_tracks_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_fall |-> (!state_q[OUT_IDX] && $past(state_q[OUT_IDX])));

    // R9: without a transition the energy total holds.
    a_r9_energy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rise && !out_fall) |-> (energy_total == $past(energy_total)));

endmodule

// File: tb/cmos_node_tracker_tb.sv
// Bench: directed scenarios against an independent reference walk for
// N=4 (narrow accumulator for saturation), N=2 and N=1.
module cmos_node_tracker_tb;

    localparam int ACC_W  = 20;
    localparam int ACC_MAX = (1 << ACC_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nd = 1'b0;
    logic [15:0] wt = 16'd0;
    logic [3:0]  in4 = '0;
    logic [1:0]  in2 = '0;
    logic        in1 = 1'b0;

    logic [3:0]  st4;
    logic [1:0]  st2;
    logic        st1;
    logic        r4, f4, c4, r2, f2, c2, r1, f1, c1;
    logic [ACC_W-1:0] en4;
    logic [31:0] en2, en1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0] e4, e2, e1;
    int exp_energy;

    always #4 clk = ~clk;

    cmos_node_tracker #(.NUM_IN(4), .WT_W(16), .ACC_W(ACC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .gate_nand(nd), .in_vec(in4), .energy_wt(wt),
        .node_state(st4), .out_rise(r4), .out_fall(f4),
        .rise_from_charged(c4), .energy_total(en4));

    cmos_node_tracker #(.NUM_IN(2)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .gate_nand(nd), .in_vec(in2), .energy_wt(wt),
        .node_state(st2), .out_rise(r2), .out_fall(f2),
        .rise_from_charged(c2), .energy_total(en2));

    cmos_node_tracker #(.NUM_IN(1)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .gate_nand(nd), .in_vec(in1), .energy_wt(wt),
        .node_state(st1), .out_rise(r1), .out_fall(f1),
        .rise_from_charged(c1), .energy_total(en1));

    // Reference: two-phase conduction walk written from the requirements.
    function automatic logic [7:0] ref_next(input logic nand_t, input int n,
                                            input logic [7:0] q, input logic [7:0] x);
        logic [7:0] r;
        bit run;
        bit par;
        r = q;
        run = 1;
        for (int i = 0; i < n; i++) begin
            if (run && (x[i] == nand_t)) r[i] = ~nand_t;
            else run = 0;
        end
        par = 0;
        for (int i = 0; i < n; i++) begin
            if (x[i] == ~nand_t) par = 1;
        end
        if (par) begin
            r[n-1] = nand_t;
            run = 1;
            for (int i = n - 1; i >= 1; i--) begin
                if (run && (x[i] == nand_t)) r[i-1] = nand_t;
                else run = 0;
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic nand_t);
        @(negedge clk);
        rst_n = 1'b0; nd = nand_t; in4 = '0; in2 = '0; in1 = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        e4 = nand_t ? 8'h08 : 8'h0F;
        e2 = nand_t ? 8'h02 : 8'h03;
        e1 = 8'h01;
        exp_energy = 0;
    endtask

    // One clock step: drive, advance, compare every output against reference.
    task automatic step(input logic [3:0] a4, input logic [1:0] a2, input logic a1,
                        input string req);
        logic [7:0] n4, n2, n1;
        bit rise, fall, src;
        n4 = ref_next(nd, 4, e4, {4'b0, a4});
        n2 = ref_next(nd, 2, e2, {6'b0, a2});
        n1 = ref_next(nd, 1, e1, {7'b0, a1});
        rise = !e4[3] && n4[3];
        fall = e4[3] && !n4[3];
        src  = rise && e4[2];
        if (rise || fall) begin
            exp_energy = exp_energy + int'(wt);
            if (exp_energy > ACC_MAX) exp_energy = ACC_MAX;
        end
        in4 = a4; in2 = a2; in1 = a1;
        @(posedge clk);
        #2;
        chk(st4 == n4[3:0], {req, " state N=4"}, st4, n4[3:0]);
        chk(st2 == n2[1:0], {req, " state N=2"}, st2, n2[1:0]);
        chk(st1 == n1[0], "R8 inverter state", st1, n1[0]);
        chk(r4 == rise && f4 == fall, "R5 pulses", {r4, f4}, {rise, fall});
        chk(c4 == src, "R7 rise source", c4, src);
        chk(c1 == 1'b0, "R7 inverter source", c1, 0);
        chk(int'(en4) == exp_energy, "R9 energy", en4, exp_energy);
        e4 = n4; e2 = n2; e1 = n1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(st4 == 4'hF && st2 == 2'b11 && st1 == 1'b1, "R1 NOR reset", st4, 4'hF);
        chk(!r4 && !f4 && en4 == '0, "R1 reset flags", {r4, f4}, 0);
        do_reset(1'b1);
        chk(st4 == 4'h8 && st2 == 2'b10 && st1 == 1'b1, "R1 NAND reset", st4, 4'h8);
    endtask

    task automatic t_nor_hold();
        do_reset(1'b0);
        wt = 16'd5;
        step(4'b0001, 2'b01, 1'b1, "R4 fall walk");
        chk(st4 == 4'b0000, "R4 discharge chain", st4, 0);
        step(4'b0010, 2'b10, 1'b0, "R3 rail walk");
        chk(st4 == 4'b0001, "R3 node0 charged", st4, 1);
        step(4'b0110, 2'b10, 1'b0, "R4 stop");
        step(4'b1111, 2'b11, 1'b1, "R4 floating hold");
        chk(st4 == 4'b0001, "R4 charge kept", st4, 1);
        step(4'b0000, 2'b00, 1'b0, "R5 rise");
        chk(r4 && !c4, "R7 rise from discharged", c4, 0);
        step(4'b1000, 2'b10, 1'b1, "R2 top-only fall");
        chk(st4 == 4'b0111, "R2 series charge", st4, 7);
        step(4'b0000, 2'b00, 1'b0, "R7 rise");
        chk(r4 && c4, "R7 rise from charged", c4, 1);
    endtask

    task automatic t_random(input logic nand_t, input int cnt);
        do_reset(nand_t);
        for (int k = 0; k < cnt; k++) begin
            wt = 16'($urandom_range(0, 300));
            step(4'($urandom), 2'($urandom), 1'($urandom), nand_t ? "R2 NAND" : "R2 NOR");
            if (!nand_t) chk(st2 != 2'b10, "R6 unreachable NOR-2", st2, 2);
        end
    endtask

    task automatic t_energy();
        do_reset(1'b0);
        wt = 16'd0;
        step(4'b0001, 2'b01, 1'b1, "R9 zero weight");
        chk(en4 == '0, "R9 zero weight", en4, 0);
        step(4'b0001, 2'b01, 1'b1, "R9 no change");
        wt = 16'hFFFF;
        step(4'b0011, 2'b01, 1'b1, "R9 no toggle");
        chk(en4 == '0, "R9 hold on no toggle", en4, 0);
        for (int k = 0; k < 18; k++) begin
            step((k % 2 == 0) ? 4'b0000 : 4'b0001, 2'b00, 1'b0, "R10 toggle");
        end
        chk(int'(en4) == ACC_MAX, "R10 saturated", en4, ACC_MAX);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_nor_hold();
        t_random(1'b0, 300);
        t_random(1'b1, 300);
        t_energy();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule